// File: doc/BRIEF.md
# Limp-Home Clock Supervisor

This block watches a clock-present indication for the external reference clock. If the clock is lost, it moves the system into a fallback mode in which everything runs from the PLL oscillator held at its minimum frequency. It does not react to the first sign of loss. Instead, a free-running counter in the crystal-domain module clock sets the polling rate, and the synchronized presence signal is sampled only when that counter sits at its midpoint value. The counter is 13 bits wide by default, which gives one poll every 8192 cycles.

While the fallback mode is active, the block overrides several clock-select controls:
- The PLL-enable and bus-select-PLL controls are driven high.
- The module-clock-select control is driven low.
- The timer, debug and peripheral clock sources are all switched to the PLL-derived clock.
- The clock monitor is held enabled.

The CAN clock-select setting is not overridden and passes through unchanged. On entry, the block freezes a shadow copy of the select controls. When a later poll finds the clock present again, the outputs return to that pre-entry copy. A status output shows whether the mode is active. Every change of that status sets a sticky interrupt flag. Software clears the flag with a write-one-to-clear pulse, and the flag raises an interrupt request when enabled.

Top module: `lhclk_supervisor`

## Requirements
- R1: The clock-present input passes through a two-flop synchronizer. The mode changes only at the clock edge that ends a cycle in which the free-running counter equals 2^(CNT_W-1). At that edge the mode becomes the inverse of the synchronized presence. After reset release, the first such edge is edge number 2^(CNT_W-1)+1, and later ones follow every 2^CNT_W edges.
- R2: While the mode is active, pll_on_o=1, bus_pll_o=1 and mod_sel_o=0.
- R3: While the mode is active, mod_src_o = 3'b111. Bit 0 is the timer source, bit 1 the debug source and bit 2 the peripheral source, and a 1 selects the PLL clock.
- R4: limp_o is 1 while the mode is active and 0 otherwise.
- R5: Each change of limp_o, on entry and on exit, sets lhif_o in the same edge. lhif_o stays set until lhif_clr_i is high at an edge with no coinciding set event. A set event wins over a clear in the same edge.
- R6: irq_o is 1 exactly when lhif_o=1 and lhie_i=1.
- R7: While the mode is active, mon_en_o=1 regardless of mon_en_i and mon_force_i. Otherwise mon_en_o = mon_en_i OR mon_force_i.
- R8: can_sel_o always equals can_sel_i, in both modes.
- R9: Outside the mode, the select outputs follow their inputs one cycle later, through a shadow register. The shadow register is frozen during the mode. In the first cycle after exit, the outputs show the values from before entry, even if the inputs changed during the mode.
- R10: After reset, limp_o=0, lhif_o=0, irq_o=0 and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-domain module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_present_i | input | 1 | Asynchronous external-clock presence from the monitor |
| pll_on_i | input | 1 | Programmed PLL enable |
| bus_pll_i | input | 1 | Programmed bus-clock-select-PLL |
| mod_sel_i | input | 1 | Programmed module-clock select |
| mod_src_i | input | 3 | Programmed timer/debug/peripheral clock sources |
| can_sel_i | input | 1 | Programmed CAN clock select |
| mon_en_i | input | 1 | Normal clock-monitor enable |
| mon_force_i | input | 1 | Forced clock-monitor enable |
| lhie_i | input | 1 | Interrupt enable |
| lhif_clr_i | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| pll_on_o | output | 1 | Effective PLL enable |
| bus_pll_o | output | 1 | Effective bus-clock-select-PLL |
| mod_sel_o | output | 1 | Effective module-clock select |
| mod_src_o | output | 3 | Effective timer/debug/peripheral sources |
| can_sel_o | output | 1 | Effective CAN clock select |
| mon_en_o | output | 1 | Effective clock-monitor enable |
| limp_o | output | 1 | Fallback-mode status |
| lhif_o | output | 1 | Sticky mode-change flag |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check these properties:
- The mode changes only just after a poll.
- The forced select values, the forced monitor enable and the CAN pass-through hold while the mode is active.
- Every mode change leaves the flag set.
- An interrupt request never appears without both the flag and the enable.

Only the bench scenarios can show the remaining behaviour:
- The exact edge numbers of the polls.
- That a loss seen between polls is ignored until the next one.
- That the pre-entry select values return on exit, even when the inputs moved during the mode.
- That a set event wins over a clear arriving in the same edge.

// File: rtl/lhs_pkg.sv
package lhs_pkg;
  typedef struct packed {
    logic       pll_on;
    logic       bus_pll;
    logic       mod_sel;
    logic [2:0] mod_src;
  } sel_t;

  // Values imposed on the clock selects while running in fallback mode.
  function automatic sel_t fallback_sel();
    sel_t s;
    s.pll_on  = 1'b1;
    s.bus_pll = 1'b1;
    s.mod_sel = 1'b0;
    s.mod_src = 3'b111;
    return s;
  endfunction

  // Next value of the sticky flag: a set beats a same-edge clear.
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/lhs_sync.sv
module lhs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end
  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lhs_poll_timer.sv
module lhs_poll_timer #(
  parameter int CNT_W = 13
) (
  input  logic clk,
  input  logic rst_n,
  output logic poll_o
);
  localparam logic [CNT_W-1:0] MID = CNT_W'(1) << (CNT_W - 1);

  function automatic logic at_mid(logic [CNT_W-1:0] c);
    return c == MID;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end
  assign poll_o = at_mid(cnt_q);
endmodule

// File: rtl/lhs_mode_ctrl.sv
module lhs_mode_ctrl
  import lhs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic poll_i,
  input  logic present_i,
  input  sel_t sel_i,
  input  logic lhif_clr_i,
  output logic limp_o,
  output logic mode_chg_o,
  output logic lhif_o,
  output sel_t sel_o
);
  logic limp_q, limp_d, lhif_q;
  sel_t shadow_q;

  assign limp_d     = poll_i ? ~present_i : limp_q;
  assign mode_chg_o = limp_d ^ limp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limp_q   <= 1'b0;
      lhif_q   <= 1'b0;
      shadow_q <= '0;
    end else begin
      limp_q <= limp_d;
      lhif_q <= flag_next(lhif_q, mode_chg_o, lhif_clr_i);
      if (!limp_q) shadow_q <= sel_i;
    end
  end

  assign limp_o = limp_q;
  assign lhif_o = lhif_q;
  assign sel_o  = limp_q ? fallback_sel() : shadow_q;
endmodule

// File: rtl/lhclk_supervisor.sv
module lhclk_supervisor
  import lhs_pkg::*;
#(
  parameter int CNT_W       = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_present_i,
  input  logic       pll_on_i,
  input  logic       bus_pll_i,
  input  logic       mod_sel_i,
  input  logic [2:0] mod_src_i,
  input  logic       can_sel_i,
  input  logic       mon_en_i,
  input  logic       mon_force_i,
  input  logic       lhie_i,
  input  logic       lhif_clr_i,
  output logic       pll_on_o,
  output logic       bus_pll_o,
  output logic       mod_sel_o,
  output logic [2:0] mod_src_o,
  output logic       can_sel_o,
  output logic       mon_en_o,
  output logic       limp_o,
  output logic       lhif_o,
  output logic       irq_o
);
  logic poll_w, present_s, mode_chg_w;
  sel_t sel_in, sel_eff;

  lhs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(clk_present_i), .q_o(present_s));

  lhs_poll_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .poll_o(poll_w));

  assign sel_in = '{pll_on: pll_on_i, bus_pll: bus_pll_i,
                    mod_sel: mod_sel_i, mod_src: mod_src_i};

  lhs_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .poll_i(poll_w), .present_i(present_s),
    .sel_i(sel_in), .lhif_clr_i(lhif_clr_i), .limp_o(limp_o),
    .mode_chg_o(mode_chg_w), .lhif_o(lhif_o), .sel_o(sel_eff));

  assign pll_on_o  = sel_eff.pll_on;
  assign bus_pll_o = sel_eff.bus_pll;
  assign mod_sel_o = sel_eff.mod_sel;
  assign mod_src_o = sel_eff.mod_src;
  assign can_sel_o = can_sel_i;
  assign mon_en_o  = limp_o | mon_en_i | mon_force_i;
  assign irq_o     = lhif_o & lhie_i;
endmodule

// File: rtl/lhs_checker.sv
module lhs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       poll_w,
  input logic       limp_o,
  input logic       lhif_o,
  input logic       irq_o,
  input logic       lhie_i,
  input logic       pll_on_o,
  input logic       bus_pll_o,
  input logic       mod_sel_o,
  input logic [2:0] mod_src_o,
  input logic       mon_en_o,
  input logic       can_sel_o,
  input logic       can_sel_i
);
  AST_CHANGE_AT_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (limp_o != $past(limp_o)) |-> $past(poll_w)); // R1
  AST_FORCED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    limp_o |-> (pll_on_o && bus_pll_o && !mod_sel_o)); // R2
  AST_FORCED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    limp_o |-> (mod_src_o == 3'b111)); // R3
  AST_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (limp_o != $past(limp_o)) |-> lhif_o); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (lhif_o && lhie_i)); // R6
  AST_MON_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    limp_o |-> mon_en_o); // R7
  AST_CAN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    limp_o |-> (can_sel_o == can_sel_i)); // R8
endmodule

bind lhclk_supervisor lhs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .poll_w(poll_w), .limp_o(limp_o),
  .lhif_o(lhif_o), .irq_o(irq_o), .lhie_i(lhie_i), .pll_on_o(pll_on_o),
  .bus_pll_o(bus_pll_o), .mod_sel_o(mod_sel_o), .mod_src_o(mod_src_o),
  .mon_en_o(mon_en_o), .can_sel_o(can_sel_o), .can_sel_i(can_sel_i));

// File: tb/lhclk_supervisor_tb_top.sv
module lhclk_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 13;
  localparam int MID   = 1 << (CNT_W - 1);
  localparam int PER   = 1 << CNT_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_present_i = 1'b1, pll_on_i = 1'b0, bus_pll_i = 1'b0, mod_sel_i = 1'b1;
  logic [2:0] mod_src_i = 3'b010;
  logic can_sel_i = 1'b0, mon_en_i = 1'b0, mon_force_i = 1'b0;
  logic lhie_i = 1'b0, lhif_clr_i = 1'b0;
  logic pll_on_o, bus_pll_o, mod_sel_o, can_sel_o, mon_en_o, limp_o, lhif_o, irq_o;
  logic [2:0] mod_src_o;

  int total = 0, bad = 0, edges = 0;

  lhclk_supervisor #(.CNT_W(CNT_W)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Return at the falling edge after rising edge number n.
  task automatic upto(int n);
    while (edges < n) @(negedge clk);
  endtask

  function automatic int poll_edge(int k);
    return MID + 1 + k * PER;
  endfunction

  task automatic t_reset();
    chk("R10 limp", limp_o, 0);
    chk("R10 lhif", lhif_o, 0);
    chk("R10 irq", irq_o, 0);
  endtask

  task automatic t_normal();
    upto(20);
    mon_en_i = 1'b1;
    #1 chk("R7 mon normal", mon_en_o, 1);
    mon_en_i = 1'b0;
    #1 chk("R7 mon off", mon_en_o, 0);
    pll_on_i = 1'b1; mod_src_i = 3'b001;
    chk("R9 lag", pll_on_o, 0);
    upto(21);
    chk("R9 follow pll", pll_on_o, 1);
    chk("R9 follow src", mod_src_o, 3'b001);
    pll_on_i = 1'b0; mod_sel_i = 1'b1; bus_pll_i = 1'b0; mod_src_i = 3'b010;
  endtask

  task automatic t_entry();
    clk_present_i = 1'b0;
    upto(poll_edge(0) - 1);
    chk("R1 before poll", limp_o, 0);
    upto(poll_edge(0));
    chk("R1 entry", limp_o, 1);
    chk("R4 status", limp_o, 1);
    chk("R5 flag entry", lhif_o, 1);
    chk("R6 irq disabled", irq_o, 0);
    lhie_i = 1'b1;
    #1 chk("R6 irq enabled", irq_o, 1);
    chk("R2 pll", pll_on_o, 1);
    chk("R2 bus", bus_pll_o, 1);
    chk("R2 mod", mod_sel_o, 0);
    chk("R3 src", mod_src_o, 3'b111);
    chk("R7 mon forced", mon_en_o, 1);
    can_sel_i = 1'b1;
    #1 chk("R8 can", can_sel_o, 1);
    lhif_clr_i = 1'b1;
    upto(poll_edge(0) + 1);
    lhif_clr_i = 1'b0;
    chk("R5 clear", lhif_o, 0);
    chk("R6 irq after clear", irq_o, 0);
    // inputs change during the mode; must not appear on exit
    mod_sel_i = 1'b0; bus_pll_i = 1'b1; mod_src_i = 3'b100;
  endtask

  task automatic t_transient();
    clk_present_i = 1'b1;
    upto(poll_edge(0) + 100);
    clk_present_i = 1'b0;
    upto(poll_edge(1));
    chk("R1 between polls ignored", limp_o, 1);
    chk("R5 no change no flag", lhif_o, 0);
  endtask

  task automatic t_exit();
    clk_present_i = 1'b1;
    upto(poll_edge(2) - 1);
    lhif_clr_i = 1'b1;
    upto(poll_edge(2));
    lhif_clr_i = 1'b0;
    chk("R1 exit", limp_o, 0);
    chk("R5 set wins", lhif_o, 1);
    chk("R9 restore mod", mod_sel_o, 1);
    chk("R9 restore bus", bus_pll_o, 0);
    chk("R9 restore src", mod_src_o, 3'b010);
    upto(poll_edge(2) + 1);
    chk("R9 resume", mod_src_o, 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_normal();
    t_entry();
    t_transient();
    t_exit();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule